// File: doc/BRIEF.md
# Real-Time Clock Snapshot and Commit Buffer

This block sits between a free-running seconds counter and the register side of a serial bus. The bus front end has already decoded bits into single-cycle strobes. When a read transfer begins, the block copies every live time byte into a frozen snapshot in one cycle. A multi-byte read then returns one consistent instant, while the counter keeps running underneath it.

A write transfer works through a shadow buffer. At the acknowledge that opens the transfer, the buffer is loaded with the current time. Each received byte overwrites only the entry it addresses. When the transfer ends validly and the write unlock is asserted, the whole buffer is copied into the live counter in one step. Aborted or locked transfers throw the buffer away.

After a commit, the sub-second count is held until the next sub-second tick, which zeroes it. This restarts the 1 Hz output from the beginning of its period. The time section holds eight byte registers. Byte 0 is the sub-second count and byte 1 is the seconds count, both in BCD. Bytes 2 to 7 are stored values that the counter does not advance.

Top module: `rtc_shadow_top`

## Requirements
- R1: Each `tick` advances byte 0 (sub-second) in BCD from 00 to 99. A tick at 99 returns it to 00 and advances byte 1 (seconds) in BCD, which wraps from 59 to 00. Bus strobes never pause the count.
- R2: `pulse_1hz` is high while the sub-second value is 00 to 49 and low while it is 50 to 99. It changes on the same edge as the sub-second value.
- R3: A `read_start_ack` cycle copies all eight live bytes into the snapshot at that edge. Without it, the snapshot keeps its contents however the live time moves.
- R4: `rd_data` is a register that presents snapshot byte `rd_addr` one cycle after the address is applied.
- R5: A `write_start_ack` cycle loads the shadow buffer with the eight live bytes and opens a write session. A `byte_wr` during an open session replaces shadow byte `byte_addr`. A `byte_wr` when no session is open has no effect.
- R6: `stop_valid` with `wr_unlock` = 1 during an open session copies shadow bytes 1 to 7 into the live registers at that edge and closes the session.
- R7: `abort`, or `stop_valid` with `wr_unlock` = 0, closes the session and leaves every live byte as it was. `abort` takes priority over `stop_valid` in the same cycle.
- R8: After a commit, byte 0 holds its value until the next tick, which sets it to 00 without a carry. `pulse_1hz` is therefore high for a fresh first half-period. Shadow byte 0 is never copied to the live registers.
- R9: In a commit, a byte that was not written during the session takes the value it had at session open, even if the live counter has since moved on.
- R10: Reset (synchronous, active high) clears all live bytes, the snapshot and `rd_data`, sets `pulse_1hz` high, and closes any session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle sub-second advance strobe |
| read_start_ack | input | 1 | Acknowledge before the first read data byte; captures the snapshot |
| write_start_ack | input | 1 | Acknowledge before the first write data byte; preloads the shadow buffer |
| byte_wr | input | 1 | Received data byte strobe |
| byte_addr | input | 3 | Time byte index for `byte_wr` |
| byte_data | input | 8 | Received data byte |
| stop_valid | input | 1 | Stop condition ending a valid transfer |
| abort | input | 1 | Transfer was invalid; drop the session |
| wr_unlock | input | 1 | Register write-enable latch state |
| rd_addr | input | 3 | Snapshot byte index for reads |
| rd_data | output | 8 | Registered snapshot byte |
| live_subsec | output | 8 | Live sub-second count, BCD |
| live_sec | output | 8 | Live seconds count, BCD |
| pulse_1hz | output | 1 | 1 Hz square wave |

## Verification
The counter outputs and `pulse_1hz` change at the clock edge that samples a tick. A commit's live bytes appear at the edge that samples `stop_valid`, and the snapshot at the edge that samples `read_start_ack`. `rd_data` trails its address by one register. The bench drives every strobe for exactly one cycle starting at a falling edge and samples at the next falling edge, which lies half a cycle after the edge that carried the change. The restart after a commit is checked in two steps: first the value that is held, then the value after the next tick. This keeps the commit and the tick in separate cycles.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int BYTE_W  = 8;
  localparam int SUB_IDX = 0;
  localparam int SEC_IDX = 1;

  typedef logic [BYTE_W-1:0] tbyte_t;

  // two-digit BCD increment, no range limit
  function automatic tbyte_t bcd_inc(input tbyte_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return v + 8'd1;
  endfunction
endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_shadow_pkg::*;
#(
  parameter int     NREGS     = 8,
  parameter tbyte_t SUB_LAST  = 8'h99,
  parameter tbyte_t SEC_LAST  = 8'h59,
  parameter tbyte_t HALF_MARK = 8'h50
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 load_en,
  input  tbyte_t [NREGS-1:0]   load_regs,
  output tbyte_t [NREGS-1:0]   live_regs,
  output logic                 hz_out
);
  logic   restart_pend;
  tbyte_t ss_nx, sec_nx;
  logic   ss_wrap;

  always_comb begin
    ss_wrap = (live_regs[SUB_IDX] == SUB_LAST);
    ss_nx   = ss_wrap ? '0 : bcd_inc(live_regs[SUB_IDX]);
    if (!ss_wrap)                           sec_nx = live_regs[SEC_IDX];
    else if (live_regs[SEC_IDX] == SEC_LAST) sec_nx = '0;
    else                                     sec_nx = bcd_inc(live_regs[SEC_IDX]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_regs    <= '0;
      restart_pend <= 1'b0;
      hz_out       <= 1'b1;
    end else if (load_en) begin
      for (int i = SUB_IDX + 1; i < NREGS; i++) live_regs[i] <= load_regs[i];
      restart_pend <= 1'b1;
    end else if (tick) begin
      if (restart_pend) begin
        live_regs[SUB_IDX] <= '0;
        restart_pend       <= 1'b0;
        hz_out             <= 1'b1;
      end else begin
        live_regs[SUB_IDX] <= ss_nx;
        live_regs[SEC_IDX] <= sec_nx;
        hz_out             <= (ss_nx < HALF_MARK);
      end
    end
  end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_shadow_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  tbyte_t [NREGS-1:0] live_regs,
  input  logic [AW-1:0]      rd_addr,
  output tbyte_t [NREGS-1:0] snap_regs,
  output tbyte_t             rd_data
);
  always_ff @(posedge clk) begin
    if (rst)          snap_regs <= '0;
    else if (capture) snap_regs <= live_regs;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= snap_regs[rd_addr];
  end
endmodule

// File: rtl/rtc_shadow_buf.sv
module rtc_shadow_buf
  import rtc_shadow_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               open_req,
  input  tbyte_t [NREGS-1:0] live_regs,
  input  logic               byte_wr,
  input  logic [AW-1:0]      byte_addr,
  input  tbyte_t             byte_data,
  input  logic               stop_valid,
  input  logic               abort,
  input  logic               wr_unlock,
  output logic               commit,
  output tbyte_t [NREGS-1:0] shadow_regs
);
  logic active;

  assign commit = active && stop_valid && wr_unlock && !abort;

  always_ff @(posedge clk) begin
    if (rst)                      shadow_regs <= '0;
    else if (open_req)            shadow_regs <= live_regs;
    else if (active && byte_wr)   shadow_regs[byte_addr] <= byte_data;
  end

  always_ff @(posedge clk) begin
    if (rst)                       active <= 1'b0;
    else if (abort || stop_valid)  active <= 1'b0;
    else if (open_req)             active <= 1'b1;
  end
endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top
  import rtc_shadow_pkg::*;
#(
  parameter int     NREGS     = 8,
  parameter tbyte_t SUB_LAST  = 8'h99,
  parameter tbyte_t SEC_LAST  = 8'h59,
  parameter tbyte_t HALF_MARK = 8'h50,
  localparam int    AW        = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          read_start_ack,
  input  logic          write_start_ack,
  input  logic          byte_wr,
  input  logic [AW-1:0] byte_addr,
  input  logic [7:0]    byte_data,
  input  logic          stop_valid,
  input  logic          abort,
  input  logic          wr_unlock,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [7:0]    live_subsec,
  output logic [7:0]    live_sec,
  output logic          pulse_1hz
);
  tbyte_t [NREGS-1:0] live_regs;
  tbyte_t [NREGS-1:0] snap_regs;
  tbyte_t [NREGS-1:0] shadow_regs;
  logic               commit_fire;

  rtc_timekeeper #(
    .NREGS(NREGS), .SUB_LAST(SUB_LAST), .SEC_LAST(SEC_LAST), .HALF_MARK(HALF_MARK)
  ) u_keep (
    .clk(clk), .rst(rst), .tick(tick),
    .load_en(commit_fire), .load_regs(shadow_regs),
    .live_regs(live_regs), .hz_out(pulse_1hz)
  );

  rtc_snapshot #(.NREGS(NREGS)) u_snap (
    .clk(clk), .rst(rst), .capture(read_start_ack),
    .live_regs(live_regs), .rd_addr(rd_addr),
    .snap_regs(snap_regs), .rd_data(rd_data)
  );

  rtc_shadow_buf #(.NREGS(NREGS)) u_shadow (
    .clk(clk), .rst(rst), .open_req(write_start_ack),
    .live_regs(live_regs), .byte_wr(byte_wr), .byte_addr(byte_addr),
    .byte_data(byte_data), .stop_valid(stop_valid), .abort(abort),
    .wr_unlock(wr_unlock), .commit(commit_fire), .shadow_regs(shadow_regs)
  );

  assign live_subsec = live_regs[SUB_IDX];
  assign live_sec    = live_regs[SEC_IDX];
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
  import rtc_shadow_pkg::*;
#(
  parameter int NREGS = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               read_start_ack,
  input logic               abort,
  input logic               commit_fire,
  input tbyte_t [NREGS-1:0] live_regs,
  input tbyte_t [NREGS-1:0] snap_regs,
  input logic [7:0]         live_subsec,
  input logic               pulse_1hz
);
  // R1
  subsec_bcd_chk: assert property (@(posedge clk) disable iff (rst)
    (live_subsec[3:0] <= 4'd9) && (live_subsec[7:4] <= 4'd9));

  // R2
  half_period_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_1hz == (live_subsec < 8'h50));

  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !read_start_ack |=> $stable(snap_regs));

  // R3
  snap_take_chk: assert property (@(posedge clk) disable iff (rst)
    read_start_ack |=> (snap_regs == $past(live_regs)));

  // R7
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit_fire |=> $stable(live_regs[NREGS-1:SEC_IDX+1]));

  // R7
  abort_block_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> !commit_fire);
endmodule

bind rtc_shadow_top rtc_shadow_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst(rst), .read_start_ack(read_start_ack), .abort(abort),
  .commit_fire(commit_fire), .live_regs(live_regs), .snap_regs(snap_regs),
  .live_subsec(live_subsec), .pulse_1hz(pulse_1hz)
);

// File: tb/sim_rtc_shadow_top.sv
module sim_rtc_shadow_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, read_start_ack = 1'b0, write_start_ack = 1'b0;
  logic       byte_wr = 1'b0, stop_valid = 1'b0, abort = 1'b0, wr_unlock = 1'b0;
  logic [2:0] byte_addr = '0, rd_addr = '0;
  logic [7:0] byte_data = '0;
  logic [7:0] rd_data, live_subsec, live_sec;
  logic       pulse_1hz;

  int n_tests = 0, n_fail = 0;
  int ss_m = 0, sec_m = 0;
  bit restart_m = 0;
  bit done = 0;
  logic [7:0] rv;
  logic [7:0] held;
  int s_keep;

  always #2 clk = ~clk;

  rtc_shadow_top u0 (
    .clk(clk), .rst(rst), .tick(tick), .read_start_ack(read_start_ack),
    .write_start_ack(write_start_ack), .byte_wr(byte_wr), .byte_addr(byte_addr),
    .byte_data(byte_data), .stop_valid(stop_valid), .abort(abort),
    .wr_unlock(wr_unlock), .rd_addr(rd_addr), .rd_data(rd_data),
    .live_subsec(live_subsec), .live_sec(live_sec), .pulse_1hz(pulse_1hz)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_live(input string req);
    chk(req, live_subsec, to_bcd(ss_m));
    chk(req, live_sec, to_bcd(sec_m));
    chk({req, " R2 pulse"}, {7'd0, pulse_1hz}, {7'd0, (ss_m < 50)});
  endtask

  // all tasks start and end at a falling edge
  task automatic do_tick();
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    if (restart_m) begin ss_m = 0; restart_m = 0; end
    else begin
      ss_m++;
      if (ss_m == 100) begin ss_m = 0; sec_m = (sec_m + 1) % 60; end
    end
  endtask

  task automatic capture();
    read_start_ack = 1'b1; @(negedge clk); read_start_ack = 1'b0;
  endtask

  task automatic read_addr(input int a, output logic [7:0] v);
    rd_addr = 3'(a); @(negedge clk); v = rd_data;
  endtask

  task automatic open_sess();
    write_start_ack = 1'b1; @(negedge clk); write_start_ack = 1'b0;
  endtask

  task automatic wbyte(input int a, input logic [7:0] d);
    byte_wr = 1'b1; byte_addr = 3'(a); byte_data = d;
    @(negedge clk); byte_wr = 1'b0;
  endtask

  task automatic stop_t(input logic unlock);
    stop_valid = 1'b1; wr_unlock = unlock; @(negedge clk);
    stop_valid = 1'b0; wr_unlock = 1'b0;
  endtask

  task automatic abort_t();
    abort = 1'b1; @(negedge clk); abort = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 subsec", live_subsec, 8'h00);
    chk("R10 sec", live_sec, 8'h00);
    chk("R10 pulse", {7'd0, pulse_1hz}, 8'h01);
    chk("R10 rd_data", rd_data, 8'h00);

    // R1 R2 sweep across a full seconds wrap
    for (int i = 0; i < 6050; i++) begin
      do_tick();
      check_live("R1 sweep");
    end

    // R3 R4 capture, then let live time move on
    capture();
    read_addr(0, rv); chk("R4 snap byte0", rv, to_bcd(ss_m));
    read_addr(1, rv); chk("R4 snap byte1", rv, to_bcd(sec_m));
    held = to_bcd(ss_m);
    for (int i = 0; i < 30; i++) do_tick();
    check_live("R1 runs after read");
    read_addr(0, rv); chk("R3 snapshot frozen", rv, held);
    for (int a = 2; a < 8; a++) begin
      read_addr(a, rv); chk("R3 snap upper", rv, 8'h00);
    end

    // R5 R6 R8 commit with a ticked-later restart
    held = live_subsec;
    open_sess();
    wbyte(1, 8'h42);
    wbyte(3, 8'hA5);
    wbyte(0, 8'h77);
    stop_t(1'b1);
    sec_m = 42; restart_m = 1;
    chk("R6 sec committed", live_sec, 8'h42);
    chk("R8 subsec held", live_subsec, held);
    do_tick();
    check_live("R8 restart");
    chk("R8 pulse restart", {7'd0, pulse_1hz}, 8'h01);
    capture();
    read_addr(3, rv); chk("R6 byte3", rv, 8'hA5);
    read_addr(2, rv); chk("R5 byte2 untouched", rv, 8'h00);
    read_addr(0, rv); chk("R8 byte0 not loaded", rv, 8'h00);
    for (int i = 0; i < 60; i++) begin
      do_tick();
      check_live("R1 after restart");
    end

    // R7 abort discards
    open_sess();
    wbyte(1, 8'h13);
    wbyte(4, 8'h5C);
    abort_t();
    check_live("R7 abort live");
    // R7 locked stop discards
    open_sess();
    wbyte(4, 8'h66);
    stop_t(1'b0);
    check_live("R7 locked stop");
    // R7 abort wins over stop in same cycle
    open_sess();
    wbyte(1, 8'h21);
    stop_valid = 1'b1; wr_unlock = 1'b1; abort = 1'b1;
    @(negedge clk);
    stop_valid = 1'b0; wr_unlock = 1'b0; abort = 1'b0;
    check_live("R7 abort priority");
    capture();
    read_addr(4, rv); chk("R7 byte4 kept", rv, 8'h00);

    // R5 byte write outside a session is ignored
    wbyte(2, 8'h99);
    stop_t(1'b1);
    check_live("R5 stray stop");
    open_sess();
    stop_t(1'b1);
    restart_m = 1;
    do_tick();
    check_live("R5 empty commit");
    capture();
    read_addr(2, rv); chk("R5 stray byte ignored", rv, 8'h00);
    read_addr(3, rv); chk("R5 byte3 kept", rv, 8'hA5);

    // R9 stale preload wins for unwritten bytes
    for (int i = 0; i < 40; i++) do_tick();
    s_keep = sec_m;
    open_sess();
    for (int i = 0; i < 250; i++) begin
      do_tick();
      check_live("R1 runs during write");
    end
    wbyte(6, 8'h3C);
    stop_t(1'b1);
    sec_m = s_keep; restart_m = 1;
    chk("R9 sec from preload", live_sec, to_bcd(s_keep));
    do_tick();
    check_live("R9 after restart");
    capture();
    read_addr(6, rv); chk("R9 byte6", rv, 8'h3C);
    read_addr(3, rv); chk("R9 byte3", rv, 8'hA5);
    read_addr(1, rv); chk("R9 snap sec", rv, to_bcd(s_keep));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule